// File: doc/BRIEF.md
# Two-to-Four-Phase Handshake Converter

This block joins a transition-signalled (two-phase) handshake to a level-signalled, return-to-zero (four-phase) handshake. Everything is sampled on one clock. On the passive side, the requester changes `req2_i` and waits for a change on `ack2_o`. On the active side, the block raises `req4_o`, waits for `ack4_i` to rise, drops `req4_o`, and waits for `ack4_i` to fall. Only after that full return-to-zero exchange does the block acknowledge the passive side by changing `ack2_o`.

An event is a change of level on an input, found by comparing the input with its registered value from the previous cycle. A small state machine fixes the order of events: a passive request, then a first active acknowledge, then a second active acknowledge, then the passive acknowledge. The acknowledges on the active side are steered alternately, the first one to the request output and the second one to the passive acknowledge. A passive request and an active acknowledge must never arrive in the same step. Any event that the current state does not expect sets a sticky error flag and is otherwise discarded. The sequence repeats without end.

Top module: `hs2to4_conv`

## Requirements
- R1: After a synchronous active-low reset, `req4_o`, `ack2_o` and `proto_err_o` are all 0, and the block is idle, waiting for a passive request.
- R2: In the idle state, a change on `req2_i` (rising or falling) with no change on `ack4_i` in the same cycle sets `req4_o` to 1 at the first clock edge that samples the new level. `ack2_o` does not change.
- R3: While `req4_o` is 1, the first change on `ack4_i` returns `req4_o` to 0 at the clock edge that samples it.
- R4: After `req4_o` has returned to 0, the next change on `ack4_i` inverts `ack2_o` one clock edge after the edge that samples it. `req4_o` stays 0.
- R5: `ack2_o` changes exactly once per completed conversion and at no other time. Conversions repeat indefinitely, so each new passive transition starts another one.
- R6: A change on `req2_i` while a conversion is in progress sets `proto_err_o` and is ignored. `req4_o` and `ack2_o` follow the active-side acknowledges exactly as in R3 and R4.
- R7: A change on `ack4_i` in the idle state sets `proto_err_o` and leaves `req4_o` and `ack2_o` unchanged.
- R8: Changes on `req2_i` and `ack4_i` in the same cycle while idle set `proto_err_o`, and neither change is accepted. The next change on `req2_i` alone starts a normal conversion.
- R9: Once set, `proto_err_o` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req2_i | input | 1 | Passive-side request; every level change is one request |
| ack2_o | output | 1 | Passive-side acknowledge; inverts once per completed conversion |
| req4_o | output | 1 | Active-side request; return-to-zero level |
| ack4_i | input | 1 | Active-side acknowledge; rises then falls once per conversion |
| proto_err_o | output | 1 | Sticky flag for any unexpected event |

## Verification
The hardest situations to reach from the ports are events that collide with the machine's internal phase. One is a passive request that arrives while the active side is halfway through its exchange. The other is a request and an acknowledge that change in the very same sampled cycle. The stimulus drives each input on the falling clock edge, so it decides exactly which rising edge first sees a change. A vector sequence flips `req2_i` back while `req4_o` is still high and then lets the conversion complete. A directed test, after reset, flips both inputs in one step. It then confirms that neither change was taken and that a lone request afterwards converts normally.

// File: rtl/hs_conv_pkg.sv
// Package: shared state encoding for the two-to-four-phase converter.
// Assumes nothing beyond a single clock domain.
package hs_conv_pkg;

    localparam int unsigned CONV_STATE_W = 2;

    // Phase of one conversion, in the order the events must occur.
    typedef enum logic [CONV_STATE_W-1:0] {
        CONV_IDLE      = 2'd0,   // waiting for a passive request
        CONV_WAIT_RISE = 2'd1,   // active request high, waiting for first ack change
        CONV_WAIT_FALL = 2'd2,   // active request low, waiting for second ack change
        CONV_ACK       = 2'd3    // issuing the passive acknowledge
    } conv_state_e;

endpackage

// File: rtl/hs_edge_det.sv
// Module: hs_edge_det
// Flags a level change on each bit of a synchronous input vector by comparing
// it with the value registered on the previous clock edge.
// Assumes inputs are already synchronous to clk; the registered copy resets
// to RESET_VAL, so an input that differs from it at reset release counts as
// an event in the first cycle.
module hs_edge_det #(
    parameter int unsigned      WIDTH     = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sig_i,
    output logic [WIDTH-1:0] evt_o
);

    logic [WIDTH-1:0] prev_q;

    // Hold last cycle's level of every input bit.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RESET_VAL;
        else        prev_q <= sig_i;
    end

    // One event flag per bit: current level differs from the held level.
    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            assign evt_o[gi] = sig_i[gi] ^ prev_q[gi];
        end
    endgenerate

endmodule

// File: rtl/hs_conv_fsm.sv
// Module: hs_conv_fsm
// Orders the events of one conversion: passive request -> raise active
// request; first active ack -> drop active request; second active ack ->
// invert passive acknowledge. Events the current state does not expect are
// discarded and set a sticky error flag.
// Assumes one-cycle event pulses from an edge detector.
module hs_conv_fsm
    import hs_conv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_evt_i,
    input  logic ack_evt_i,
    output logic req4_o,
    output logic ack2_o,
    output logic err_o
);

    conv_state_e st_q, st_d;
    logic        req4_q, req4_d;
    logic        ack2_q, ack2_d;
    logic        err_q, err_set;

    // Next state, output toggles and error detection for the current event pair.
    always_comb begin
        st_d    = st_q;
        req4_d  = req4_q;
        ack2_d  = ack2_q;
        err_set = 1'b0;
        unique case (st_q)
            CONV_IDLE: begin
                if (req_evt_i && ack_evt_i) begin
                    err_set = 1'b1;
                end else if (req_evt_i) begin
                    st_d   = CONV_WAIT_RISE;
                    req4_d = ~req4_q;
                end else if (ack_evt_i) begin
                    err_set = 1'b1;
                end
            end
            CONV_WAIT_RISE: begin
                if (ack_evt_i) begin
                    st_d   = CONV_WAIT_FALL;
                    req4_d = ~req4_q;
                end
                if (req_evt_i) err_set = 1'b1;
            end
            CONV_WAIT_FALL: begin
                if (ack_evt_i) st_d = CONV_ACK;
                if (req_evt_i) err_set = 1'b1;
            end
            CONV_ACK: begin
                st_d   = CONV_IDLE;
                ack2_d = ~ack2_q;
                if (req_evt_i || ack_evt_i) err_set = 1'b1;
            end
            default: st_d = CONV_IDLE;
        endcase
    end

    // State and output registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= CONV_IDLE;
            req4_q <= 1'b0;
            ack2_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            req4_q <= req4_d;
            ack2_q <= ack2_d;
            err_q  <= err_q | err_set;
        end
    end

    assign req4_o = req4_q;
    assign ack2_o = ack2_q;
    assign err_o  = err_q;

    AST_REQ_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CONV_IDLE && req_evt_i && !ack_evt_i) |=> (req4_q && st_q == CONV_WAIT_RISE)); // R2
    AST_REQ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CONV_WAIT_RISE && ack_evt_i) |=> !req4_q); // R3
    AST_ACK_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CONV_WAIT_FALL && ack_evt_i) |=> ##1 (ack2_q != $past(ack2_q))); // R4
    AST_ACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != CONV_ACK) |=> $stable(ack2_q)); // R5
    AST_BUSY_REQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != CONV_IDLE && req_evt_i) |=> err_q); // R6
    AST_IDLE_ACK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CONV_IDLE && ack_evt_i) |=> (err_q && $stable(req4_q))); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q); // R9

endmodule

// File: rtl/hs2to4_conv.sv
// Module: hs2to4_conv (top)
// Bridges a passive transition-signalled handshake to an active
// return-to-zero handshake: each passive request yields one full four-phase
// exchange, then one passive acknowledge.
// Assumes req2_i and ack4_i are synchronous to clk.
module hs2to4_conv
    import hs_conv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req2_i,
    output logic ack2_o,
    output logic req4_o,
    input  logic ack4_i,
    output logic proto_err_o
);

    localparam int unsigned N_IN   = 2;
    localparam int unsigned IDX_RQ = 0;
    localparam int unsigned IDX_AK = 1;

    logic [N_IN-1:0] in_lvl;
    logic [N_IN-1:0] in_evt;

    assign in_lvl[IDX_RQ] = req2_i;
    assign in_lvl[IDX_AK] = ack4_i;

    hs_edge_det #(
        .WIDTH     (N_IN),
        .RESET_VAL ('0)
    ) edge_i (
        .clk   (clk),
        .rst_n (rst_n),
        .sig_i (in_lvl),
        .evt_o (in_evt)
    );

    hs_conv_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_evt_i (in_evt[IDX_RQ]),
        .ack_evt_i (in_evt[IDX_AK]),
        .req4_o    (req4_o),
        .ack2_o    (ack2_o),
        .err_o     (proto_err_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!req4_o && !ack2_o && !proto_err_o)); // R1

endmodule

// File: tb/hs2to4_conv_tb_top.sv
`timescale 1ns/1ps
module hs2to4_conv_tb_top;

    localparam real HALF_NS  = 2.5;
    localparam int  N_VEC    = 14;
    localparam int  WD_LIMIT = 5000;

    logic clk = 1'b0;
    logic rst_n;
    logic req2, ack4;
    logic ack2, req4, perr;

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #(HALF_NS) clk = ~clk;

    hs2to4_conv dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req2_i      (req2),
        .ack2_o      (ack2),
        .req4_o      (req4),
        .ack4_i      (ack4),
        .proto_err_o (perr)
    );

    // Vector: {req tag[3:0], req2, ack4, exp req4, exp ack2, exp err}
    typedef logic [8:0] vec_t;
    localparam vec_t VECS [N_VEC] = '{
        {4'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},  // R2 rising passive request
        {4'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},  // R3 first ack change
        {4'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},  // R4 second ack change seen
        {4'd4, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // R4 passive ack inverts
        {4'd5, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // R5 no further change
        {4'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},  // R2 falling passive request
        {4'd3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},  // R3
        {4'd4, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R4
        {4'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R5 second conversion acked
        {4'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},  // R2 third conversion
        {4'd6, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},  // R6 request while busy
        {4'd6, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},  // R6 exchange continues
        {4'd6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},  // R6
        {4'd6, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}   // R6 conversion completes
    };

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag, input logic ec, input logic eb, input logic ee);
        check(tag, "req4_o", req4, ec);
        check(tag, "ack2_o", ack2, eb);
        check(tag, "proto_err_o", perr, ee);
    endtask

    // Drive inputs at the falling edge; the next rising edge samples them.
    task automatic step(input logic a, input logic d);
        @(negedge clk);
        req2 = a;
        ack4 = d;
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        req2  = 1'b0;
        ack4  = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected under %0d", cyc, WD_LIMIT);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        req2  = 1'b0;
        ack4  = 1'b0;
        do_reset();
        check_all("R1", 1'b0, 1'b0, 1'b0);

        for (int i = 0; i < N_VEC; i++) begin
            step(VECS[i][4], VECS[i][3]);
            @(negedge clk);
            check_all($sformatf("R%0d vec%0d", VECS[i][8:5], i),
                      VECS[i][2], VECS[i][1], VECS[i][0]);
            req2 = VECS[i][4];
            ack4 = VECS[i][3];
        end

        // R1: reset clears the sticky error left by the vectors.
        do_reset();
        @(negedge clk);
        check_all("R1 after error", 1'b0, 1'b0, 1'b0);

        // R7: ack change while idle.
        step(1'b0, 1'b1);
        @(negedge clk);
        check_all("R7", 1'b0, 1'b0, 1'b1);

        // R9: error holds over idle cycles.
        repeat (5) @(negedge clk);
        check("R9", "proto_err_o", perr, 1'b1);

        // R8: both inputs change in one step while idle.
        do_reset();
        step(1'b1, 1'b1);
        @(negedge clk);
        check_all("R8 collision", 1'b0, 1'b0, 1'b1);
        repeat (2) @(negedge clk);
        check("R8 none taken", "ack2_o", ack2, 1'b0);
        // A lone request afterwards starts a normal conversion.
        step(1'b0, 1'b1);
        @(negedge clk);
        check("R8 later request", "req4_o", req4, 1'b1);
        step(1'b0, 1'b0);
        @(negedge clk);
        check("R8 R3", "req4_o", req4, 1'b0);
        step(1'b0, 1'b1);
        repeat (2) @(negedge clk);
        check("R8 R4", "ack2_o", ack2, 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule